// File: doc/BRIEF.md
# Amplitude-Binned Timing Slew Corrector

This block corrects a timing measurement by using the amplitude measured on a paired channel. The amplitude is a 12-bit unsigned value that has already had its pedestal removed. It is sorted into one of eight bins, and each bin has its own programmable upper limit. The signed offset that belongs to the chosen bin is then added to the timing value. The result is clamped to the 12-bit range and leaves the block two clock cycles after the sample entered. The block accepts a new sample on every clock.

The block sits after offset or pedestal subtraction and before any channel masking. Only timing channels carry a correction; every other channel passes its timing value through unchanged. Each timing channel has its own table of limits and offsets, loaded one entry at a time through a write port. After reset the table holds neutral values, so the block behaves as a two-stage delay line until it is configured.

Top module: `slew_corr`

## Requirements
- R1: Every timing channel holds eight bins, and each bin has a 12-bit upper limit and an 8-bit two's complement offset. A write with `cfg_sel_i`=0 stores `cfg_data_i[11:0]` as the limit of bin `cfg_bin_i` of channel `cfg_ch_i`. A write with `cfg_sel_i`=1 stores `cfg_data_i[7:0]` as that bin's offset and ignores bits 11:8. A write takes effect for samples presented on later cycles.
- R2: An amplitude lies in bin N when it is strictly above limit N-1 and no greater than limit N. Bin 0 has a floor of zero, so an amplitude of 0 falls into bin 0.
- R3: The selected bin is the lowest bin whose limit is at least the amplitude. If no limit qualifies, bin 7 is used.
- R4: A channel is a timing channel when bit 2 of its 5-bit number is set, which gives channels 4-7, 12-15, 20-23 and 28-31. Every other channel leaves with its timing value unchanged, and configuration writes that name such a channel have no effect.
- R5: The corrected timing equals the input timing plus the selected offset, saturated to the range 0 to 4095.
- R6: `out_valid_o` is high exactly two clock edges after each cycle in which `in_valid_i` was sampled high, and low otherwise. Samples may arrive on consecutive cycles.
- R7: Reset forces all limits to 4095 and all offsets to zero, and keeps `out_valid_o` low. After reset, every channel passes its timing value unchanged.
- R8: A timing channel that is reprogrammed to all limits 4095 and all offsets zero outputs its timing value unchanged at any amplitude.
- R9: When several bins share the same limit, an amplitude equal to that limit goes to the lowest of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 5 | Channel addressed by the write |
| cfg_bin_i | input | 3 | Bin addressed by the write |
| cfg_sel_i | input | 1 | 0 writes a limit, 1 writes an offset |
| cfg_data_i | input | 12 | Limit value, or offset in bits 7:0 |
| in_valid_i | input | 1 | Input sample strobe |
| in_ch_i | input | 5 | Channel of the sample |
| in_amp_i | input | 12 | Pedestal-subtracted amplitude |
| in_time_i | input | 12 | Timing value to correct |
| out_valid_o | output | 1 | Corrected sample strobe |
| out_time_o | output | 12 | Corrected timing value |

## Verification
The table is read in the same cycle that a sample is accepted. The assertions and the bench therefore assume that no configuration write arrives in the same cycle as a sample. The stimulus keeps writes and samples on separate cycles. The lower-edge check on the bin choice relies only on the priority order, so it holds even when the limits are not sorted. The stimulus still programs non-decreasing limits, including runs of equal limits. It also programs a channel whose top limit lies below full scale, which forces the fallback to bin 7. The amplitude and timing inputs are always driven with known values, both during reset and between samples.

// File: rtl/slew_pkg.sv
package slew_pkg;
  localparam int unsigned NUM_CH   = 32;
  localparam int unsigned NUM_BINS = 8;
  localparam int unsigned AMP_W    = 12;
  localparam int unsigned TIME_W   = 12;
  localparam int unsigned OFS_W    = 8;

  typedef enum logic {
    SEL_LIMIT  = 1'b0,
    SEL_OFFSET = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/slew_cfg_table.sv
module slew_cfg_table
  import slew_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned N_BINS = NUM_BINS,
  parameter int unsigned A_W    = AMP_W,
  parameter int unsigned O_W    = OFS_W,
  localparam int unsigned CH_W   = $clog2(N_CH),
  localparam int unsigned BIN_W  = $clog2(N_BINS),
  localparam int unsigned N_TCH  = N_CH / 2,
  localparam int unsigned TIDX_W = CH_W - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [CH_W-1:0]              wch_i,
  input  logic [BIN_W-1:0]             wbin_i,
  input  logic                         wsel_i,
  input  logic [A_W-1:0]               wdata_i,
  input  logic [CH_W-1:0]              rch_i,
  output logic                         rtiming_o,
  output logic [N_BINS-1:0][A_W-1:0]   lim_o,
  output logic [N_BINS-1:0][O_W-1:0]   ofs_o
);
  // timing channels have bit 2 set; drop that bit to index the table
  logic              wr_tch;
  logic [TIDX_W-1:0] wr_idx;
  logic [TIDX_W-1:0] rd_idx;

  assign wr_tch    = wch_i[2];
  assign wr_idx    = {wch_i[CH_W-1:3], wch_i[1:0]};
  assign rd_idx    = {rch_i[CH_W-1:3], rch_i[1:0]};
  assign rtiming_o = rch_i[2];

  logic [A_W-1:0] lim_q [N_TCH][N_BINS];
  logic [O_W-1:0] ofs_q [N_TCH][N_BINS];

  for (genvar c = 0; c < N_TCH; c++) begin : g_ch
    for (genvar b = 0; b < N_BINS; b++) begin : g_bin
      logic hit;
      assign hit = we_i && wr_tch && (wr_idx == TIDX_W'(c)) && (wbin_i == BIN_W'(b));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lim_q[c][b] <= '1;
          ofs_q[c][b] <= '0;
        end else if (hit) begin
          if (cfg_sel_e'(wsel_i) == SEL_LIMIT) lim_q[c][b] <= wdata_i;
          else                                 ofs_q[c][b] <= wdata_i[O_W-1:0];
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < N_BINS; b++) begin
      lim_o[b] = lim_q[rd_idx][b];
      ofs_o[b] = ofs_q[rd_idx][b];
    end
  end

  // R1
  lim_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_tch && wsel_i == SEL_LIMIT) |=>
      lim_q[$past(wr_idx)][$past(wbin_i)] == $past(wdata_i));

  // R1
  ofs_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_tch && wsel_i == SEL_OFFSET) |=>
      ofs_q[$past(wr_idx)][$past(wbin_i)] == $past(wdata_i[O_W-1:0]));
endmodule

// File: rtl/slew_bin_sel.sv
module slew_bin_sel
  import slew_pkg::*;
#(
  parameter int unsigned N_BINS = NUM_BINS,
  parameter int unsigned A_W    = AMP_W,
  localparam int unsigned BIN_W = $clog2(N_BINS)
) (
  input  logic [A_W-1:0]             amp_i,
  input  logic [N_BINS-1:0][A_W-1:0] lim_i,
  output logic [BIN_W-1:0]           bin_o
);
  logic [N_BINS-1:0] hit;

  for (genvar b = 0; b < N_BINS; b++) begin : g_cmp
    assign hit[b] = (amp_i <= lim_i[b]);
  end

  // lowest qualifying bin wins; top bin is the fallback
  always_comb begin
    bin_o = BIN_W'(N_BINS - 1);
    for (int b = N_BINS - 1; b >= 0; b--) begin
      if (hit[b]) bin_o = BIN_W'(b);
    end
  end
endmodule

// File: rtl/slew_sat_add.sv
module slew_sat_add
  import slew_pkg::*;
#(
  parameter int unsigned T_W = TIME_W,
  parameter int unsigned O_W = OFS_W,
  localparam int unsigned S_W = T_W + 2
) (
  input  logic [T_W-1:0] t_i,
  input  logic [O_W-1:0] ofs_i,
  output logic [T_W-1:0] y_o
);
  logic signed [S_W-1:0] t_ext;
  logic signed [S_W-1:0] o_ext;
  logic signed [S_W-1:0] sum;

  assign t_ext = $signed({2'b00, t_i});
  assign o_ext = $signed({{(S_W-O_W){ofs_i[O_W-1]}}, ofs_i});
  assign sum   = t_ext + o_ext;

  always_comb begin
    if (sum[S_W-1])             y_o = '0;
    else if (|sum[S_W-2:T_W])   y_o = '1;
    else                        y_o = sum[T_W-1:0];
  end
endmodule

// File: rtl/slew_corr.sv
module slew_corr
  import slew_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned N_BINS = NUM_BINS,
  parameter int unsigned A_W    = AMP_W,
  parameter int unsigned T_W    = TIME_W,
  parameter int unsigned O_W    = OFS_W,
  localparam int unsigned CH_W  = $clog2(N_CH),
  localparam int unsigned BIN_W = $clog2(N_BINS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [BIN_W-1:0]  cfg_bin_i,
  input  logic              cfg_sel_i,
  input  logic [A_W-1:0]    cfg_data_i,
  input  logic              in_valid_i,
  input  logic [CH_W-1:0]   in_ch_i,
  input  logic [A_W-1:0]    in_amp_i,
  input  logic [T_W-1:0]    in_time_i,
  output logic              out_valid_o,
  output logic [T_W-1:0]    out_time_o
);
  logic                       tbl_timing;
  logic [N_BINS-1:0][A_W-1:0] tbl_lim;
  logic [N_BINS-1:0][O_W-1:0] tbl_ofs;
  logic [BIN_W-1:0]           bin_sel;

  slew_cfg_table #(.N_CH(N_CH), .N_BINS(N_BINS), .A_W(A_W), .O_W(O_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wch_i     (cfg_ch_i),
    .wbin_i    (cfg_bin_i),
    .wsel_i    (cfg_sel_i),
    .wdata_i   (cfg_data_i),
    .rch_i     (in_ch_i),
    .rtiming_o (tbl_timing),
    .lim_o     (tbl_lim),
    .ofs_o     (tbl_ofs)
  );

  slew_bin_sel #(.N_BINS(N_BINS), .A_W(A_W)) u_bin (
    .amp_i (in_amp_i),
    .lim_i (tbl_lim),
    .bin_o (bin_sel)
  );

  // stage 1: bin pick and offset lookup
  logic           s1_valid_q;
  logic           s1_apply_q;
  logic [T_W-1:0] s1_time_q;
  logic [O_W-1:0] s1_ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_apply_q <= 1'b0;
      s1_time_q  <= '0;
      s1_ofs_q   <= '0;
    end else begin
      s1_valid_q <= in_valid_i;
      if (in_valid_i) begin
        s1_apply_q <= tbl_timing;
        s1_time_q  <= in_time_i;
        s1_ofs_q   <= tbl_timing ? tbl_ofs[bin_sel] : '0;
      end
    end
  end

  // stage 2: saturating add
  logic [T_W-1:0] sat_y;

  slew_sat_add #(.T_W(T_W), .O_W(O_W)) u_add (
    .t_i   (s1_time_q),
    .ofs_i (s1_ofs_q),
    .y_o   (sat_y)
  );

  logic           out_valid_q;
  logic [T_W-1:0] out_time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_time_q  <= '0;
    end else begin
      out_valid_q <= s1_valid_q;
      if (s1_valid_q) out_time_q <= s1_apply_q ? sat_y : s1_time_q;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_time_o  = out_time_q;

  // checker-side sum, wide enough to never wrap
  logic signed [T_W+1:0] chk_sum;
  assign chk_sum = $signed({2'b00, s1_time_q}) + $signed(s1_ofs_q);

  // R6
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 2));

  // R4
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !$past(in_ch_i[2], 2)) |-> out_time_o == $past(in_time_i, 2));

  // R3
  upper_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (bin_sel == BIN_W'(N_BINS - 1)) || (in_amp_i <= tbl_lim[bin_sel]));

  // R2
  lower_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && bin_sel != '0) |-> in_amp_i > tbl_lim[bin_sel - 1'b1]);

  // R5
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_apply_q && chk_sum < 0) |=> out_time_o == '0);

  // R5
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_apply_q && chk_sum > $signed({2'b00, {T_W{1'b1}}})) |=> out_time_o == '1);
endmodule

// File: tb/slew_corr_bench.sv
module slew_corr_bench;
  localparam int NCH = 32;
  localparam int NB  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_ch = '0;
  logic [2:0]  cfg_bin = '0;
  logic        cfg_sel = 1'b0;
  logic [11:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [4:0]  in_ch = '0;
  logic [11:0] in_amp = '0;
  logic [11:0] in_time = '0;
  logic        out_valid;
  logic [11:0] out_time;

  always #5 clk = ~clk;

  slew_corr u_slew_corr (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_bin_i(cfg_bin),
    .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .in_valid_i(in_valid), .in_ch_i(in_ch), .in_amp_i(in_amp), .in_time_i(in_time),
    .out_valid_o(out_valid), .out_time_o(out_time)
  );

  int lim_m [NCH][NB];
  int ofs_m [NCH][NB];

  typedef struct { int due; int t; string req; } exp_t;
  exp_t exq[$];

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always @(posedge clk) cyc++;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % m);
  endfunction

  function automatic int model(int ch, int amp, int t);
    int bin;
    int s;
    if (((ch >> 2) & 1) == 0) return t;
    bin = NB - 1;
    for (int b = NB - 1; b >= 0; b--) if (amp <= lim_m[ch][b]) bin = b;
    s = t + ofs_m[ch][bin];
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return s;
  endfunction

  // compare on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exq.size() > 0 && exq[0].due == cyc) begin
        exp_t e;
        e = exq.pop_front();
        chk({e.req, " valid"}, int'(out_valid), 1);
        chk({e.req, " time"}, int'(out_time), e.t);
      end else begin
        chk("R6 idle", int'(out_valid), 0);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); #1;
      in_valid = 1'b0;
      cfg_we   = 1'b0;
    end
  endtask

  task automatic wr(int ch, int bin, int sel, int data);
    @(negedge clk); #1;
    in_valid = 1'b0;
    cfg_we   = 1'b1;
    cfg_ch   = 5'(ch);
    cfg_bin  = 3'(bin);
    cfg_sel  = sel[0];
    cfg_data = 12'(data);
    if (((ch >> 2) & 1) == 1) begin
      if (sel == 0) lim_m[ch][bin] = data & 12'hFFF;
      else begin
        int o;
        o = data & 8'hFF;
        if (o > 127) o -= 256;
        ofs_m[ch][bin] = o;
      end
    end
  endtask

  task automatic prog(int ch, input int l[NB], input int o[NB]);
    for (int b = 0; b < NB; b++) wr(ch, b, 0, l[b]);
    for (int b = 0; b < NB; b++) wr(ch, b, 1, o[b] & 8'hFF);
  endtask

  task automatic send(int ch, int amp, int t, string req);
    exp_t e;
    @(negedge clk); #1;
    cfg_we   = 1'b0;
    in_valid = 1'b1;
    in_ch    = 5'(ch);
    in_amp   = 12'(amp);
    in_time  = 12'(t);
    e.due = cyc + 2;
    e.t   = model(ch, amp, t);
    e.req = req;
    exq.push_back(e);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < NB; b++) begin
        lim_m[c][b] = 4095;
        ofs_m[c][b] = 0;
      end

    // R7: reset state
    repeat (3) @(negedge clk);
    chk("R7 reset valid", int'(out_valid), 0);
    #1 rst_n = 1'b1;
    idle(2);

    // R7: unconfigured channels pass through
    for (int c = 0; c < NCH; c++) send(c, rnd(4096), rnd(4096), "R7");
    idle(3);

    // R2: bin edges on a programmed channel
    prog(5, '{30, 60, 95, 135, 200, 300, 600, 4095},
            '{105, 53, 22, 4, -10, -23, -40, -58});
    idle(1);
    send(5, 0,    1000, "R2 zero");
    send(5, 30,   1000, "R2 b0 top");
    send(5, 31,   1000, "R2 b1 low");
    send(5, 60,   1000, "R2 b1 top");
    send(5, 61,   1000, "R2 b2 low");
    send(5, 135,  1000, "R2 b3 top");
    send(5, 600,  1000, "R2 b6 top");
    send(5, 601,  1000, "R2 b7 low");
    send(5, 4095, 1000, "R2 full");
    idle(3);

    // R5: saturation
    send(5, 0,    4000, "R5 high sat");
    send(5, 0,    3990, "R5 exact max");
    send(5, 4095, 30,   "R5 low sat");
    send(5, 4095, 58,   "R5 exact zero");
    send(5, 200,  0,    "R5 neg at zero");
    idle(3);

    // R1: offset write uses low byte only
    wr(13, 0, 1, 12'hAF6);
    idle(1);
    send(13, 7, 500, "R1 offset low byte");
    wr(13, 0, 0, 10);
    wr(13, 1, 1, 20);
    idle(1);
    send(13, 10, 500, "R1 limit");
    send(13, 11, 500, "R1 next bin");
    idle(3);

    // R3: no limit qualifies, top bin used
    prog(7, '{50, 50, 50, 50, 50, 50, 50, 50}, '{1, 2, 3, 4, 5, 6, 7, 9});
    idle(1);
    send(7, 51,   300, "R3 fallback");
    send(7, 4095, 300, "R3 fallback max");
    send(7, 50,   300, "R3 at limit");
    idle(3);

    // R9: repeated limits
    prog(6, '{100, 100, 100, 200, 300, 400, 500, 4095}, '{10, 20, 30, 40, 50, 60, 70, -80});
    idle(1);
    send(6, 100, 2000, "R9 tie");
    send(6, 99,  2000, "R9 below tie");
    send(6, 101, 2000, "R9 above tie");
    idle(3);

    // R4: writes to non-timing channels ignored
    wr(9, 0, 1, 50);
    wr(0, 0, 0, 0);
    wr(0, 0, 1, 100);
    wr(27, 3, 1, 127);
    idle(1);
    send(9,  0,   700, "R4 ch9");
    send(0,  5,   700, "R4 ch0");
    send(27, 100, 700, "R4 ch27");
    send(3,  0,   700, "R4 ch3");
    send(8,  0,   700, "R4 ch8");
    idle(3);

    // R6: back-to-back stream on mixed channels
    for (int i = 0; i < 300; i++) send(rnd(32), rnd(4096), rnd(4096), "R6 stream");
    idle(3);
    send(6, 150, 10, "R6 single");
    idle(1);
    send(5, 61, 10, "R6 gap");
    idle(4);

    // R8: neutral reprogramming restores pass-through
    prog(5, '{4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095}, '{0, 0, 0, 0, 0, 0, 0, 0});
    idle(1);
    send(5, 0,    1234, "R8 amp0");
    send(5, 61,   4095, "R8 mid");
    send(5, 4095, 0,    "R8 full");
    idle(5);

    chk("R6 drained", exq.size(), 0);
    finish_run();
  end
endmodule